// File: doc/BRIEF.md
# I2C GPIO Expander Target Interface

This block is the serial control front end of an 8-bit general-purpose I/O expander. It watches an I2C bus through an oversampled system clock and pulls SDA low, open-drain, when it must acknowledge or send a zero. It answers one of two individual addresses, picked by a strap input. It also answers a shared broadcast address, so one write can program every expander on the bus with the same settings.

Each write transfer starts with a command byte, which loads a register pointer. The bytes that follow land in successive control registers, and the pointer wraps around the eight-entry map. A read transfer streams out successive registers from the same pointer. The register outputs feed the pin-control logic: direction, output value, read polarity, bus-hold, pull enable, pull direction and interrupt mask. Index 0 returns the synchronised pin levels, XOR-ed with the polarity register.

A power-on reset input and a hardware reset pin, both active low, restore every register to its default and send the protocol engine back to idle.

Top module: `i2c_gpio_target`

## Requirements
- R1: While `por_n` or `rst_n` is low, and after reset is released, `dir_o` = 8'hFF (every pin an input, 1 = input), `irq_mask_o` = 8'hFF (every interrupt masked, 1 = masked), and `out_o`, `invert_o`, `hold_en_o`, `pull_en_o`, `pull_up_o` are all 8'h00.
- R2: With `addr_sel` = 0 the block acknowledges 7-bit address 7'h20 (address byte 8'h40/8'h41). With `addr_sel` = 1 it acknowledges 7'h21 (8'h42/8'h43). Any other address is not acknowledged and changes no register.
- R3: A write to the broadcast address 7'h68 (address byte 8'hD0) is acknowledged and programs the registers exactly as an individual-address write does.
- R4: A read to the broadcast address (address byte 8'hD1) is not acknowledged: SDA stays released during the acknowledge bit.
- R5: In a write, the first byte after the address is a command byte whose low three bits load the pointer. Each later byte is written to the pointed register, and the pointer then steps by one, wrapping from 7 to 0. Map: 0 pins (read-only), 1 `invert_o`, 2 `hold_en_o`, 3 `pull_en_o`, 4 `pull_up_o`, 5 `dir_o`, 6 `out_o`, 7 `irq_mask_o`. Register outputs change only while SCL is low.
- R6: In a read, the block sends the pointed register MSB first, then steps the pointer. It continues while the controller acknowledges, and stops driving after a not-acknowledge.
- R7: A write to index 0 is acknowledged but has no effect. Reading index 0 returns `gpio_in` XOR `invert_o`.
- R8: A STOP in the middle of a byte aborts it without a register write. A START in the middle of a byte abandons it, and the next byte is treated as an address.
- R9: Transfers work at Standard-mode (100 kHz) and Fast-mode (400 kHz) SCL rates with the system clock at 50 MHz.
- R10: Pulling `rst_n` low in the middle of a transfer releases SDA by the next clock and restores the R1 defaults. A fresh transfer then works normally.
- R11: The block starts driving SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | Hardware reset pin, active low, asynchronous |
| addr_sel | input | 1 | Strap choosing the individual address LSB |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| gpio_in | input | W | Pin levels for read-back |
| dir_o | output | W | Direction, 1 = input |
| out_o | output | W | Output drive values |
| invert_o | output | W | Read polarity inversion |
| hold_en_o | output | W | Bus-hold enable |
| pull_en_o | output | W | Pull resistor enable |
| pull_up_o | output | W | Pull direction, 1 = up |
| irq_mask_o | output | W | Interrupt mask, 1 = masked |

## Verification
The bench builds the block with its defaults: W = 8, a two-stage synchroniser, base address 7'h20 and broadcast address 7'h68. With those values both strap addresses and the broadcast address can be reached, and so can every index of the eight-entry map, including the wrap from index 7 to the read-only index 0. The two-stage synchroniser keeps the target's reaction a few clocks after each SCL edge, so a Fast-mode quarter bit of 32 clocks and a Standard-mode quarter bit of 125 clocks both exercise the real acknowledge and data timing.

// File: rtl/i2c_gpio_pkg.sv
package i2c_gpio_pkg;

   localparam int unsigned NUM_REGS = 8;
   localparam int unsigned PTR_W    = $clog2(NUM_REGS);

   // register indices; order matters for pointer auto-increment
   localparam logic [PTR_W-1:0] IX_PINS    = 3'd0;
   localparam logic [PTR_W-1:0] IX_INVERT  = 3'd1;
   localparam logic [PTR_W-1:0] IX_HOLD    = 3'd2;
   localparam logic [PTR_W-1:0] IX_PULLEN  = 3'd3;
   localparam logic [PTR_W-1:0] IX_PULLUP  = 3'd4;
   localparam logic [PTR_W-1:0] IX_DIR     = 3'd5;
   localparam logic [PTR_W-1:0] IX_OUT     = 3'd6;
   localparam logic [PTR_W-1:0] IX_MASK    = 3'd7;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK
   } bus_st_e;

   typedef enum logic [1:0] {
      BK_ADDR,
      BK_CMD,
      BK_DATA
   } byte_kind_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det,
   output logic sda_lvl
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_sh;
   logic [STAGES-1:0] sda_sh;
   logic              scl_s;
   logic              sda_s;
   logic              scl_q;
   logic              sda_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[STAGES-2:0], scl_in};
         sda_sh <= {sda_sh[STAGES-2:0], sda_in};
         scl_q  <= scl_s;
         sda_q  <= sda_s;
      end
   end

   assign scl_s     = scl_sh[STAGES-1];
   assign sda_s     = sda_sh[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
   assign sda_lvl   = sda_s;

endmodule

// File: rtl/i2c_target_engine.sv
module i2c_target_engine
   import i2c_gpio_pkg::*;
#(
   parameter logic [6:0] ADDR_BASE = 7'h20,
   parameter logic [6:0] ALL_CALL  = 7'h68
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             addr_sel,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic             sda_lvl,
   input  logic [7:0]       rd_data,
   output logic [PTR_W-1:0] rd_idx,
   output logic             wr_en,
   output logic [PTR_W-1:0] wr_idx,
   output logic [7:0]       wr_data,
   output logic             sda_oe
);

   localparam int unsigned BYTE_BITS = 8;
   localparam int unsigned CNT_W     = $clog2(BYTE_BITS + 1);

   bus_st_e          st;
   byte_kind_e       kind;
   logic [CNT_W-1:0] bitcnt;
   logic [7:0]       shreg;
   logic             rw;
   logic [PTR_W-1:0] ptr;
   logic [6:0]       own_addr;
   logic             addr_hit;

   assign own_addr = ADDR_BASE | {6'd0, addr_sel};
   // broadcast address accepted only for writes
   assign addr_hit = (shreg[7:1] == own_addr) ||
                     ((shreg[7:1] == ALL_CALL) && !shreg[0]);
   assign rd_idx   = ptr;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         st      <= ST_IDLE;
         kind    <= BK_ADDR;
         bitcnt  <= '0;
         shreg   <= '0;
         rw      <= 1'b0;
         ptr     <= '0;
         sda_oe  <= 1'b0;
         wr_en   <= 1'b0;
         wr_idx  <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            st     <= ST_RX;
            kind   <= BK_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (st)
               ST_RX: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[6:0], sda_lvl};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall && bitcnt == CNT_W'(BYTE_BITS)) begin
                     unique case (kind)
                        BK_ADDR: begin
                           if (addr_hit) begin
                              rw     <= shreg[0];
                              st     <= ST_ACK;
                              sda_oe <= 1'b1;
                           end else begin
                              st <= ST_IDLE;
                           end
                        end
                        BK_CMD: begin
                           ptr    <= shreg[PTR_W-1:0];
                           kind   <= BK_DATA;
                           st     <= ST_ACK;
                           sda_oe <= 1'b1;
                        end
                        default: begin
                           wr_en   <= 1'b1;
                           wr_idx  <= ptr;
                           wr_data <= shreg;
                           ptr     <= ptr + 1'b1;
                           st      <= ST_ACK;
                           sda_oe  <= 1'b1;
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (rw) begin
                        shreg  <= rd_data;
                        ptr    <= ptr + 1'b1;
                        sda_oe <= ~rd_data[7];
                        st     <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        st     <= ST_RX;
                        if (kind == BK_ADDR) kind <= BK_CMD;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bitcnt == CNT_W'(BYTE_BITS - 1)) begin
                        sda_oe <= 1'b0;
                        st     <= ST_MACK;
                     end else begin
                        shreg  <= {shreg[6:0], 1'b0};
                        sda_oe <= ~shreg[6];
                        bitcnt <= bitcnt + 1'b1;
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise && sda_lvl) begin
                     st <= ST_IDLE;
                  end else if (scl_fall) begin
                     shreg  <= rd_data;
                     ptr    <= ptr + 1'b1;
                     sda_oe <= ~rd_data[7];
                     bitcnt <= '0;
                     st     <= ST_TX;
                  end
               end
               default: begin
                  sda_oe <= 1'b0;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
   import i2c_gpio_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             wr_en,
   input  logic [PTR_W-1:0] wr_idx,
   input  logic [7:0]       wr_data,
   input  logic [PTR_W-1:0] rd_idx,
   input  logic [W-1:0]     gpio_in,
   output logic [7:0]       rd_data,
   output logic [W-1:0]     dir_o,
   output logic [W-1:0]     out_o,
   output logic [W-1:0]     invert_o,
   output logic [W-1:0]     hold_en_o,
   output logic [W-1:0]     pull_en_o,
   output logic [W-1:0]     pull_up_o,
   output logic [W-1:0]     irq_mask_o
);

   logic [W-1:0] bank [1:NUM_REGS-1];
   logic [W-1:0] pin_s1;
   logic [W-1:0] pin_s2;
   logic [W-1:0] pin_view;
   logic [W-1:0] rd_word;

   for (genvar r = 1; r < NUM_REGS; r++) begin : g_reg
      localparam logic [W-1:0] RST_VAL =
         ((PTR_W'(r) == IX_DIR) || (PTR_W'(r) == IX_MASK)) ? '1 : '0;
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) begin
            bank[r] <= RST_VAL;
         end else if (wr_en && wr_idx == PTR_W'(r)) begin
            bank[r] <= wr_data[W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         pin_s1 <= '0;
         pin_s2 <= '0;
      end else begin
         pin_s1 <= gpio_in;
         pin_s2 <= pin_s1;
      end
   end

   assign pin_view = pin_s2 ^ bank[IX_INVERT];

   always_comb begin
      if (rd_idx == IX_PINS) rd_word = pin_view;
      else                   rd_word = bank[rd_idx];
   end

   assign rd_data    = 8'(rd_word);
   assign invert_o   = bank[IX_INVERT];
   assign hold_en_o  = bank[IX_HOLD];
   assign pull_en_o  = bank[IX_PULLEN];
   assign pull_up_o  = bank[IX_PULLUP];
   assign dir_o      = bank[IX_DIR];
   assign out_o      = bank[IX_OUT];
   assign irq_mask_o = bank[IX_MASK];

endmodule

// File: rtl/i2c_gpio_target.sv
module i2c_gpio_target
   import i2c_gpio_pkg::*;
#(
   parameter int unsigned W           = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [6:0]  ADDR_BASE   = 7'h20,
   parameter logic [6:0]  ALL_CALL    = 7'h68
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         rst_n,
   input  logic         addr_sel,
   input  logic         scl_in,
   input  logic         sda_in,
   output logic         sda_oe,
   input  logic [W-1:0] gpio_in,
   output logic [W-1:0] dir_o,
   output logic [W-1:0] out_o,
   output logic [W-1:0] invert_o,
   output logic [W-1:0] hold_en_o,
   output logic [W-1:0] pull_en_o,
   output logic [W-1:0] pull_up_o,
   output logic [W-1:0] irq_mask_o
);

   if (W < 1 || W > 8) begin : g_bad_width
      $error("i2c_gpio_target: W must be 1..8");
   end
   if (ADDR_BASE[0] != 1'b0) begin : g_bad_base
      $error("i2c_gpio_target: ADDR_BASE LSB is taken by the strap");
   end
   if (ALL_CALL[6:1] == ADDR_BASE[6:1]) begin : g_bad_call
      $error("i2c_gpio_target: broadcast address overlaps individual pair");
   end

   logic             arst_n;
   logic             scl_rise;
   logic             scl_fall;
   logic             start_det;
   logic             stop_det;
   logic             sda_lvl;
   logic [7:0]       rd_data;
   logic [PTR_W-1:0] rd_idx;
   logic             wr_en;
   logic [PTR_W-1:0] wr_idx;
   logic [7:0]       wr_data;

   assign arst_n = por_n & rst_n;

   i2c_line_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk       (clk),
      .arst_n    (arst_n),
      .scl_in    (scl_in),
      .sda_in    (sda_in),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_lvl   (sda_lvl)
   );

   i2c_target_engine #(
      .ADDR_BASE (ADDR_BASE),
      .ALL_CALL  (ALL_CALL)
   ) u_engine (
      .clk       (clk),
      .arst_n    (arst_n),
      .addr_sel  (addr_sel),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_lvl   (sda_lvl),
      .rd_data   (rd_data),
      .rd_idx    (rd_idx),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .sda_oe    (sda_oe)
   );

   gpio_ctrl_regs #(
      .W (W)
   ) u_regs (
      .clk        (clk),
      .arst_n     (arst_n),
      .wr_en      (wr_en),
      .wr_idx     (wr_idx),
      .wr_data    (wr_data),
      .rd_idx     (rd_idx),
      .gpio_in    (gpio_in),
      .rd_data    (rd_data),
      .dir_o      (dir_o),
      .out_o      (out_o),
      .invert_o   (invert_o),
      .hold_en_o  (hold_en_o),
      .pull_en_o  (pull_en_o),
      .pull_up_o  (pull_up_o),
      .irq_mask_o (irq_mask_o)
   );

endmodule

// File: rtl/i2c_gpio_target_chk.sv
module i2c_gpio_target_chk #(
   parameter int unsigned W = 8
) (
   input logic         clk,
   input logic         por_n,
   input logic         rst_n,
   input logic         scl_in,
   input logic         sda_oe,
   input logic [W-1:0] dir_o,
   input logic [W-1:0] out_o,
   input logic [W-1:0] irq_mask_o
);

   // R1
   reset_defaults_chk: assert property (@(posedge clk)
      (!por_n || !rst_n) |=> (dir_o == '1 && irq_mask_o == '1 && out_o == '0));

   // R10
   pin_reset_release_chk: assert property (@(posedge clk)
      !rst_n |=> !sda_oe);

   // R11
   drive_scl_low_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      $rose(sda_oe) |-> !scl_in);

   // R5
   out_update_scl_low_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      !$stable(out_o) |-> !scl_in);

   // R5
   dir_update_scl_low_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      !$stable(dir_o) |-> !scl_in);

endmodule

bind i2c_gpio_target i2c_gpio_target_chk #(.W(W)) u_chk (
   .clk        (clk),
   .por_n      (por_n),
   .rst_n      (rst_n),
   .scl_in     (scl_in),
   .sda_oe     (sda_oe),
   .dir_o      (dir_o),
   .out_o      (out_o),
   .irq_mask_o (irq_mask_o)
);

// File: tb/sim_i2c_gpio_target.sv
`timescale 1ns/1ps
module sim_i2c_gpio_target;

   localparam int unsigned W       = 8;
   localparam int          Q_FAST  = 32;
   localparam int          Q_STD   = 125;
   localparam int          WD_LIM  = 190000;

   logic         clk = 1'b0;
   logic         por_n = 1'b0;
   logic         rst_n = 1'b0;
   logic         addr_sel = 1'b0;
   logic         scl_m = 1'b1;
   logic         sda_m = 1'b1;
   logic         sda_bus;
   logic         sda_oe;
   logic [W-1:0] gpio_in = 8'h96;
   logic [W-1:0] dir_o, out_o, invert_o, hold_en_o, pull_en_o, pull_up_o, irq_mask_o;

   int checks = 0;
   int fails  = 0;
   int q      = Q_FAST;
   int oe_viol = 0;
   logic oe_prev = 1'b0;

   always #10 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   i2c_gpio_target u0 (
      .clk        (clk),
      .por_n      (por_n),
      .rst_n      (rst_n),
      .addr_sel   (addr_sel),
      .scl_in     (scl_m),
      .sda_in     (sda_bus),
      .sda_oe     (sda_oe),
      .gpio_in    (gpio_in),
      .dir_o      (dir_o),
      .out_o      (out_o),
      .invert_o   (invert_o),
      .hold_en_o  (hold_en_o),
      .pull_en_o  (pull_en_o),
      .pull_up_o  (pull_up_o),
      .irq_mask_o (irq_mask_o)
   );

   // R11 monitor: target must not begin pulling SDA while SCL is high
   always @(negedge clk) begin
      if (sda_oe && !oe_prev && scl_m && por_n && rst_n) oe_viol++;
      oe_prev = sda_oe;
   end

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wq();
      repeat (q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b0; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b1; wq();
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; wq();
      scl_m = 1'b1; wq(); wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ack);
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      ack = ~sda_bus;
      wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic recv_byte(output logic [7:0] d, input logic give_ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; wq();
         scl_m = 1'b1; wq();
         d[i] = sda_bus;
         wq();
         scl_m = 1'b0; wq();
      end
      send_bit(~give_ack);
   endtask

   task automatic t_reset();
      repeat (5) @(negedge clk);
      // R1: values held during reset
      check("R1 dir in reset", dir_o, 8'hFF);
      por_n = 1'b1;
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R1 dir", dir_o, 8'hFF);
      check("R1 mask", irq_mask_o, 8'hFF);
      check("R1 out", out_o, 8'h00);
      check("R1 invert", invert_o, 8'h00);
      check("R1 hold", hold_en_o, 8'h00);
      check("R1 pull_en", pull_en_o, 8'h00);
      check("R1 pull_up", pull_up_o, 8'h00);
      check("R1 sda_oe", {7'd0, sda_oe}, 8'h00);
   endtask

   task automatic t_write_auto();
      logic a;
      q = Q_FAST;
      addr_sel = 1'b0;
      bus_start();
      send_byte(8'h40, a); check("R2 ack 0x20", {7'd0, a}, 8'h01);
      send_byte(8'h05, a); check("R5 cmd ack", {7'd0, a}, 8'h01);
      send_byte(8'hA5, a);
      send_byte(8'h3C, a);
      send_byte(8'h0F, a);
      bus_stop();
      check("R5 dir", dir_o, 8'hA5);
      check("R5 out", out_o, 8'h3C);
      check("R5 mask", irq_mask_o, 8'h0F);
      bus_start();
      send_byte(8'h40, a);
      send_byte(8'h07, a);
      send_byte(8'h11, a);
      send_byte(8'h22, a); check("R7 idx0 write acked", {7'd0, a}, 8'h01);
      send_byte(8'h33, a);
      bus_stop();
      check("R5 wrap mask", irq_mask_o, 8'h11);
      check("R5 wrap invert", invert_o, 8'h33);
      check("R7 dir untouched", dir_o, 8'hA5);
   endtask

   task automatic t_read();
      logic a;
      logic [7:0] d;
      q = Q_FAST;
      bus_start();
      send_byte(8'h40, a);
      send_byte(8'h00, a);
      bus_start();
      send_byte(8'h41, a); check("R6 read addr ack", {7'd0, a}, 8'h01);
      recv_byte(d, 1'b1); check("R7 pins xor invert", d, 8'h96 ^ 8'h33);
      recv_byte(d, 1'b1); check("R6 invert readback", d, 8'h33);
      recv_byte(d, 1'b0); check("R6 hold readback", d, 8'h00);
      check("R6 released after nack", {7'd0, sda_oe}, 8'h00);
      bus_stop();
   endtask

   task automatic t_addr_sel();
      logic a;
      q = Q_FAST;
      addr_sel = 1'b1;
      repeat (4) @(negedge clk);
      bus_start();
      send_byte(8'h40, a); check("R2 0x20 ignored when strap=1", {7'd0, a}, 8'h00);
      send_byte(8'h06, a);
      send_byte(8'hEE, a);
      bus_stop();
      check("R2 out unchanged", out_o, 8'h3C);
      bus_start();
      send_byte(8'h42, a); check("R2 ack 0x21", {7'd0, a}, 8'h01);
      send_byte(8'h06, a);
      send_byte(8'h81, a);
      bus_stop();
      check("R2 out via 0x21", out_o, 8'h81);
   endtask

   task automatic t_allcall();
      logic a;
      q = Q_FAST;
      bus_start();
      send_byte(8'hD0, a); check("R3 broadcast write ack", {7'd0, a}, 8'h01);
      send_byte(8'h02, a);
      send_byte(8'h55, a);
      bus_stop();
      check("R3 hold via broadcast", hold_en_o, 8'h55);
      bus_start();
      send_byte(8'hD1, a); check("R4 broadcast read nack", {7'd0, a}, 8'h00);
      bus_stop();
      check("R4 hold intact", hold_en_o, 8'h55);
   endtask

   task automatic t_abort();
      logic a;
      q = Q_FAST;
      bus_start();
      send_byte(8'h42, a);
      send_byte(8'h06, a);
      for (int i = 0; i < 4; i++) send_bit(1'b1);
      bus_stop();
      check("R8 stop mid-byte no write", out_o, 8'h81);
      bus_start();
      send_byte(8'h42, a);
      send_byte(8'h06, a);
      for (int i = 0; i < 4; i++) send_bit(1'b0);
      bus_start();
      send_byte(8'h42, a); check("R8 address after mid-byte start", {7'd0, a}, 8'h01);
      send_byte(8'h04, a);
      send_byte(8'h77, a);
      bus_stop();
      check("R8 pull_up written", pull_up_o, 8'h77);
      check("R8 out untouched", out_o, 8'h81);
   endtask

   task automatic t_std_mode();
      logic a;
      logic [7:0] d;
      q = Q_STD;
      bus_start();
      send_byte(8'h42, a); check("R9 std addr ack", {7'd0, a}, 8'h01);
      send_byte(8'h03, a);
      send_byte(8'hC3, a);
      bus_stop();
      check("R9 std pull_en", pull_en_o, 8'hC3);
      bus_start();
      send_byte(8'h42, a);
      send_byte(8'h03, a);
      bus_start();
      send_byte(8'h43, a);
      recv_byte(d, 1'b0); check("R9 std readback", d, 8'hC3);
      bus_stop();
      q = Q_FAST;
   endtask

   task automatic t_hw_reset();
      logic a;
      q = Q_FAST;
      bus_start();
      send_byte(8'h42, a);
      send_byte(8'h06, a);
      for (int i = 0; i < 3; i++) send_bit(1'b1);
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 sda released", {7'd0, sda_oe}, 8'h00);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R10 out default", out_o, 8'h00);
      check("R10 dir default", dir_o, 8'hFF);
      check("R10 mask default", irq_mask_o, 8'hFF);
      check("R10 pull_up default", pull_up_o, 8'h00);
      bus_start();
      send_byte(8'h42, a); check("R10 fresh ack", {7'd0, a}, 8'h01);
      send_byte(8'h06, a);
      send_byte(8'h5A, a);
      bus_stop();
      check("R10 fresh write", out_o, 8'h5A);
   endtask

   initial begin
      t_reset();
      t_write_auto();
      t_read();
      t_addr_sel();
      t_allcall();
      t_abort();
      t_std_mode();
      t_hw_reset();
      check("R11 drive only with SCL low", 8'(oe_viol), 8'h00);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (WD_LIM) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule